// File: doc/BRIEF.md
# Real-Time Clock Alarm Comparator with Wildcard Fields

This block decides, at every once-per-second update of a real-time clock, whether the freshly updated time of day matches the programmed alarm. It takes three alarm bytes (seconds, minutes, hours) and the three current-time bytes, decodes each into a plain number and compares them field by field. When they match it produces a one-cycle pulse that the surrounding logic uses to set the alarm flag. Holding the alarm byte storage, the flag register and the interrupt enable is the job of the neighbouring logic.

Any alarm byte whose two top bits are both 1 is a wildcard and matches every current value. Setting all three fields to wildcards makes the pulse fire on every update. The bytes are read as packed BCD or as plain binary, depending on a mode input. The hour bytes are read in either 24-hour form or 12-hour form. In 12-hour form the top bit flags PM and is removed before the hour is normalised to a 0..23 value. The same hour rule applies to both the alarm hour and the current hour, so the two are compared on equal terms. While the clock is held for setting, no update takes place and no match is reported.

Top module: `rtc_alarm_cmp`

## Requirements
- R1: While rst_n is low at a rising clock edge, alarm_hit is 0 after that edge, whatever the other inputs are.
- R2: alarm_hit is 1 for exactly the one cycle that follows a rising edge at which upd_pulse=1, set_hold=0 and all three fields match. In every other cycle it is 0, and this includes any cycle after an edge at which upd_pulse=0.
- R3: With bin_mode=0, every byte is decoded as BCD, with the value equal to upper nibble × 10 + lower nibble. For example, alarm 0x10 matches current 0x0A, because both decode to 10.
- R4: With bin_mode=1, every byte is taken as a plain binary value. For example, alarm 0x10 (16) does not match current 0x0A (10), while alarm 0x3B matches current 0x3B.
- R5: An alarm byte with bits [7:6]=2'b11 is a wildcard, and that field matches whatever the current byte holds.
- R6: When all three alarm bytes are wildcards, every qualifying update (upd_pulse=1 and set_hold=0) produces alarm_hit.
- R7: With hr24_mode=0, bit 7 of each hour byte marks PM. Bits [6:0] are decoded, reduced modulo 12, and then increased by 12 when PM is set. For example, 0x12 (12 AM) matches 0x00, 0x92 (12 PM) does not match 0x12, and in binary mode 0x8C matches 0x80.
- R8: With hr24_mode=1, the whole hour byte is decoded with no PM handling. For example, 0x12 does not match 0x00, and 0x81 does not match 0x01.
- R9: While set_hold=1, an update pulse never produces alarm_hit.
- R10: A current-time byte with bits [7:6]=2'b11 is invalid. It matches only a wildcard alarm byte in that field.
- R11: A mismatch in any single non-wildcard field suppresses alarm_hit, even when the other two fields match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| upd_pulse | input | 1 | One-cycle strobe marking that the time bytes have just been updated |
| set_hold | input | 1 | Clock held for setting; suppresses matching |
| bin_mode | input | 1 | 1 = binary bytes, 0 = BCD bytes |
| hr24_mode | input | 1 | 1 = 24-hour hour bytes, 0 = 12-hour with PM in bit 7 |
| alm_sec | input | 8 | Alarm seconds byte |
| alm_min | input | 8 | Alarm minutes byte |
| alm_hr | input | 8 | Alarm hours byte |
| cur_sec | input | 8 | Current seconds byte |
| cur_min | input | 8 | Current minutes byte |
| cur_hr | input | 8 | Current hours byte |
| alarm_hit | output | 1 | One-cycle alarm-match pulse |

## Verification
The bound checker checks four things on every cycle. No pulse appears without a preceding update strobe, and none appears while the clock is held for setting. A qualifying update with all fields wildcarded always fires. Identical hour bytes with wildcarded seconds and minutes always fire, in every mode. The bench's scenarios cover the rest. These are the numeric decoding of BCD versus binary, the 12-hour PM normalisation, including 12 AM equalling 0, invalid current bytes, the one-cycle width of the pulse and the behaviour under reset. Each of these depends on particular byte values that a generic property cannot predict.

// File: rtl/rtcal_pkg.sv
// Package: shared constants and the decoded-field type for the alarm comparator.
// Assumes three time fields ordered seconds, minutes, hours.
package rtcal_pkg;
    localparam int BYTE_W   = 8;
    localparam int VAL_W    = 8;
    localparam int N_FIELDS = 3;
    localparam int HOUR_IDX = 2;

    typedef struct packed {
        logic             wild;   // byte carried the all-ones top-bits marker
        logic [VAL_W-1:0] val;    // normalised numeric value
    } fld_t;
endpackage

// File: rtl/rtcal_field_dec.sv
// Module: rtcal_field_dec
// Turns one raw time byte into a normalised value plus a wildcard marker.
// Assumes: bin_mode selects binary versus BCD; twelve_hr is asserted only for
// hour bytes in 12-hour form, where bit 7 is the PM marker.
module rtcal_field_dec
    import rtcal_pkg::*;
(
    input  logic [BYTE_W-1:0] raw,
    input  logic              bin_mode,
    input  logic              twelve_hr,
    output fld_t              fld
);
    logic [BYTE_W-1:0] body;
    logic [VAL_W-1:0]  num;
    logic [VAL_W-1:0]  hr_mod;

    // Strip the PM marker when the byte is a 12-hour hour.
    always_comb body = twelve_hr ? {1'b0, raw[BYTE_W-2:0]} : raw;

    // Convert BCD or binary to a plain number.
    always_comb begin
        if (bin_mode)
            num = body;
        else
            num = ({4'd0, body[7:4]} * 8'd10) + {4'd0, body[3:0]};
    end

    // Map 12-hour values into 0..23: modulo 12, then add 12 for PM.
    always_comb hr_mod = num % 8'd12;

    // Assemble the decoded field.
    always_comb begin
        fld.wild = &raw[BYTE_W-1:BYTE_W-2];
        fld.val  = twelve_hr ? (hr_mod + (raw[BYTE_W-1] ? 8'd12 : 8'd0)) : num;
    end
endmodule

// File: rtl/rtcal_match.sv
// Module: rtcal_match
// Reduces per-field comparisons into one match flag.
// Assumes a wildcard alarm field always matches; an invalid (wildcard-marked)
// current field matches only a wildcard alarm field.
module rtcal_match
    import rtcal_pkg::*;
(
    input  fld_t alm [N_FIELDS],
    input  fld_t cur [N_FIELDS],
    output logic all_match
);
    logic [N_FIELDS-1:0] fld_ok;

    for (genvar g = 0; g < N_FIELDS; g++) begin : g_cmp
        // One field agrees when wildcarded or when both valid values are equal.
        always_comb fld_ok[g] = alm[g].wild ||
                                (!cur[g].wild && (alm[g].val == cur[g].val));
    end

    // All fields must agree.
    always_comb all_match = &fld_ok;
endmodule

// File: rtl/rtc_alarm_cmp.sv
// Module: rtc_alarm_cmp (top)
// Compares the alarm bytes with the just-updated time bytes on each update
// strobe and emits a one-cycle match pulse on the following cycle.
// Assumes the current-time bytes are already updated in the strobe cycle and
// that no update is evaluated while set_hold is asserted.
module rtc_alarm_cmp
    import rtcal_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              upd_pulse,
    input  logic              set_hold,
    input  logic              bin_mode,
    input  logic              hr24_mode,
    input  logic [BYTE_W-1:0] alm_sec,
    input  logic [BYTE_W-1:0] alm_min,
    input  logic [BYTE_W-1:0] alm_hr,
    input  logic [BYTE_W-1:0] cur_sec,
    input  logic [BYTE_W-1:0] cur_min,
    input  logic [BYTE_W-1:0] cur_hr,
    output logic              alarm_hit
);
    logic [BYTE_W-1:0] alm_raw [N_FIELDS];
    logic [BYTE_W-1:0] cur_raw [N_FIELDS];
    fld_t              alm_fld [N_FIELDS];
    fld_t              cur_fld [N_FIELDS];
    logic              fields_match;

    // Gather the bytes into field-indexed arrays (seconds, minutes, hours).
    always_comb begin
        alm_raw[0] = alm_sec;
        alm_raw[1] = alm_min;
        alm_raw[2] = alm_hr;
        cur_raw[0] = cur_sec;
        cur_raw[1] = cur_min;
        cur_raw[2] = cur_hr;
    end

    for (genvar g = 0; g < N_FIELDS; g++) begin : g_fld
        logic twelve;
        if (g == HOUR_IDX) begin : g_hour
            // Hour fields use the 12-hour rule when 24-hour form is off.
            always_comb twelve = !hr24_mode;
        end else begin : g_plain
            // Seconds and minutes never carry a PM marker.
            always_comb twelve = 1'b0;
        end

        rtcal_field_dec u_alm_dec (
            .raw      (alm_raw[g]),
            .bin_mode (bin_mode),
            .twelve_hr(twelve),
            .fld      (alm_fld[g])
        );

        rtcal_field_dec u_cur_dec (
            .raw      (cur_raw[g]),
            .bin_mode (bin_mode),
            .twelve_hr(twelve),
            .fld      (cur_fld[g])
        );
    end

    rtcal_match u_match (
        .alm      (alm_fld),
        .cur      (cur_fld),
        .all_match(fields_match)
    );

    // Register the qualified match into a one-cycle pulse.
    always_ff @(posedge clk) begin
        if (!rst_n)
            alarm_hit <= 1'b0;
        else
            alarm_hit <= upd_pulse && !set_hold && fields_match;
    end
endmodule

// File: rtl/rtcal_chk.sv
// Module: rtcal_chk
// Assertion checker bound to rtc_alarm_cmp; observes its ports only.
module rtcal_chk
    import rtcal_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              upd_pulse,
    input logic              set_hold,
    input logic              bin_mode,
    input logic              hr24_mode,
    input logic [BYTE_W-1:0] alm_sec,
    input logic [BYTE_W-1:0] alm_min,
    input logic [BYTE_W-1:0] alm_hr,
    input logic [BYTE_W-1:0] cur_sec,
    input logic [BYTE_W-1:0] cur_min,
    input logic [BYTE_W-1:0] cur_hr,
    input logic              alarm_hit
);
    logic started;
    logic rst_q;

    // Track that one edge has passed and the reset level seen at it.
    always_ff @(posedge clk) begin
        started <= 1'b1;
        rst_q   <= rst_n;
    end

    // R1: after an edge with reset low the pulse is clear.
    always @(negedge clk) begin
        if (started === 1'b1 && rst_q === 1'b0)
            a_reset_clear_r1: assert (alarm_hit == 1'b0);
    end

    // R2: no strobe, no pulse on the next cycle.
    p_no_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_pulse |=> !alarm_hit);

    // R9: a held clock never reports a match.
    p_hold_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        set_hold |=> !alarm_hit);

    // R6: all-wildcard alarm fires on each qualifying update.
    p_all_wild_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_pulse && !set_hold && (&alm_sec[7:6]) && (&alm_min[7:6]) &&
         (&alm_hr[7:6])) |=> alarm_hit);

    // R5: identical valid hour bytes with wildcarded seconds and minutes match
    // in any mode.
    p_same_hour_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_pulse && !set_hold && (&alm_sec[7:6]) && (&alm_min[7:6]) &&
         (alm_hr == cur_hr) && !(&cur_hr[7:6]) && (bin_mode || !bin_mode) &&
         (hr24_mode || !hr24_mode) && (cur_sec == cur_sec) &&
         (cur_min == cur_min)) |=> alarm_hit);
endmodule

bind rtc_alarm_cmp rtcal_chk u_chk (.*);

// File: tb/rtc_alarm_cmp_tb.sv
module rtc_alarm_cmp_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       upd_pulse = 1'b0;
    logic       set_hold = 1'b0;
    logic       bin_mode = 1'b0;
    logic       hr24_mode = 1'b1;
    logic [7:0] alm_sec = 8'h00, alm_min = 8'h00, alm_hr = 8'h00;
    logic [7:0] cur_sec = 8'h00, cur_min = 8'h00, cur_hr = 8'h00;
    logic       alarm_hit;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    rtc_alarm_cmp u_dut (.*);

    // Vector layout: [55:52] req, [51] hold, [50] bin, [49] h24,
    // [48:41] alm_sec, [40:33] alm_min, [32:25] alm_hr,
    // [24:17] cur_sec, [16:9] cur_min, [8:1] cur_hr, [0] expected hit
    localparam int NV = 19;
    localparam logic [55:0] VEC [NV] = '{
        {4'd3,  3'b001, 8'h30, 8'h45, 8'h23, 8'h30, 8'h45, 8'h23, 1'b1}, // R3 exact BCD
        {4'd11, 3'b001, 8'h31, 8'h45, 8'h23, 8'h30, 8'h45, 8'h23, 1'b0}, // R11 seconds differ
        {4'd11, 3'b001, 8'h30, 8'h44, 8'h23, 8'h30, 8'h45, 8'h23, 1'b0}, // R11 minutes differ
        {4'd11, 3'b001, 8'h30, 8'h45, 8'h22, 8'h30, 8'h45, 8'h23, 1'b0}, // R11 hours differ
        {4'd4,  3'b011, 8'h3B, 8'h2D, 8'h17, 8'h3B, 8'h2D, 8'h17, 1'b1}, // R4 binary exact
        {4'd3,  3'b001, 8'h10, 8'h00, 8'h00, 8'h0A, 8'h00, 8'h00, 1'b1}, // R3 0x10 == 0x0A in BCD
        {4'd4,  3'b011, 8'h10, 8'h00, 8'h00, 8'h0A, 8'h00, 8'h00, 1'b0}, // R4 16 != 10
        {4'd5,  3'b001, 8'hC5, 8'h45, 8'h23, 8'h17, 8'h45, 8'h23, 1'b1}, // R5 seconds wild
        {4'd5,  3'b001, 8'h30, 8'h45, 8'hFF, 8'h30, 8'h45, 8'h09, 1'b1}, // R5 hours wild
        {4'd6,  3'b001, 8'hC0, 8'hFF, 8'hD3, 8'h12, 8'h34, 8'h05, 1'b1}, // R6 all wild
        {4'd7,  3'b000, 8'h00, 8'h00, 8'h12, 8'h00, 8'h00, 8'h00, 1'b1}, // R7 12 AM equals 0
        {4'd7,  3'b000, 8'h00, 8'h00, 8'h92, 8'h00, 8'h00, 8'h12, 1'b0}, // R7 12 PM vs 12 AM
        {4'd7,  3'b000, 8'h00, 8'h00, 8'h81, 8'h00, 8'h00, 8'h81, 1'b1}, // R7 1 PM both
        {4'd7,  3'b000, 8'h00, 8'h00, 8'h81, 8'h00, 8'h00, 8'h01, 1'b0}, // R7 1 PM vs 1 AM
        {4'd7,  3'b010, 8'h00, 8'h00, 8'h8C, 8'h00, 8'h00, 8'h80, 1'b1}, // R7 binary 12h PM
        {4'd8,  3'b001, 8'h00, 8'h00, 8'h12, 8'h00, 8'h00, 8'h00, 1'b0}, // R8 12 != 0 in 24h
        {4'd10, 3'b001, 8'h00, 8'h45, 8'h23, 8'hC0, 8'h45, 8'h23, 1'b0}, // R10 invalid current
        {4'd10, 3'b001, 8'hC0, 8'h45, 8'h23, 8'hC0, 8'h45, 8'h23, 1'b1}, // R10 wild vs invalid
        {4'd9,  3'b101, 8'hC0, 8'hC0, 8'hC0, 8'h00, 8'h00, 8'h00, 1'b0}  // R9 hold blocks
    };

    task automatic check(input logic got, input logic exp, input string req, input string what);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0b expected=%0b", req, what, got, exp);
        end
    endtask

    task automatic load(input logic [55:0] v);
        set_hold  = v[51];
        bin_mode  = v[50];
        hr24_mode = v[49];
        alm_sec = v[48:41]; alm_min = v[40:33]; alm_hr = v[32:25];
        cur_sec = v[24:17]; cur_min = v[16:9];  cur_hr = v[8:1];
    endtask

    initial begin
        // R1: reset holds the output low even with an all-wild strobe
        @(negedge clk);
        alm_sec = 8'hC0; alm_min = 8'hC0; alm_hr = 8'hC0;
        upd_pulse = 1'b1;
        @(negedge clk);
        check(alarm_hit, 1'b0, "R1", "reset with strobe");
        @(negedge clk);
        upd_pulse = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        check(alarm_hit, 1'b0, "R1", "after reset release");

        // Table walk: strobe one cycle, check the following cycle
        for (int i = 0; i < NV; i++) begin
            load(VEC[i]);
            upd_pulse = 1'b1;
            @(negedge clk);
            upd_pulse = 1'b0;
            check(alarm_hit, VEC[i][0], $sformatf("R%0d", VEC[i][55:52]),
                  $sformatf("vector %0d", i));
            @(negedge clk);
            check(alarm_hit, 1'b0, "R2", $sformatf("pulse width vector %0d", i));
            set_hold = 1'b0;
        end

        // R2: matching inputs without a strobe give no pulse
        load({4'd2, 3'b001, 8'h30, 8'h45, 8'h23, 8'h30, 8'h45, 8'h23, 1'b0});
        @(negedge clk);
        @(negedge clk);
        check(alarm_hit, 1'b0, "R2", "match without strobe");

        // R2: back-to-back strobes give back-to-back pulses, then it drops
        upd_pulse = 1'b1;
        @(negedge clk);
        check(alarm_hit, 1'b1, "R2", "first consecutive strobe");
        @(negedge clk);
        check(alarm_hit, 1'b1, "R2", "second consecutive strobe");
        upd_pulse = 1'b0;
        @(negedge clk);
        check(alarm_hit, 1'b0, "R2", "after strobes end");

        // R1: reset asserted together with a qualifying strobe
        upd_pulse = 1'b1;
        rst_n = 1'b0;
        @(negedge clk);
        check(alarm_hit, 1'b0, "R1", "reset mid-run");
        upd_pulse = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check
    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog R2 actual=running expected=finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule